// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the fetch, decode and memory-operand execution engine of a small 16-bit computer built around one accumulator. It holds a 4096-word by 16-bit memory that is written on the clock edge and read without a clock. A program counter and an address register, both 12 bits wide, sit beside a 16-bit instruction register, a 16-bit data register, the accumulator and a one-bit carry latch. A three-bit timing counter steps the machine through states T0 to T6, and a run flag gates that counter.

Each instruction word carries a 12-bit address in its low bits, a 3-bit operation code above it and an indirect flag in the top bit. Operation codes 0 to 6 are executed here: bitwise AND, add with carry, load, store, unconditional branch, branch-and-save-return and increment-and-skip-if-zero. When the flag is set, one level of indirection is resolved first. Code 7 covers register and I/O operations. The block does not execute these. It presents them on a strobe to a neighbouring execute unit, waits one clock, and then either fetches the next instruction or stops when that unit asks for a halt.

A loader port writes words into memory while reset is held, and a peek port reads any word back. The loader port takes priority over writes made by the program.

Top module: `accSequencer`

## Requirements
- R1: While reset is held, the PC reads 0, the accumulator reads 0, the carry reads 0, the run flag reads 1 and the timing state reads 0. After release, the first fetch is from address 0.
- R2: An instruction word is split as follows: bits 11..0 give the address, bits 14..12 give the operation code, and bit 15 gives the indirect flag. Every fetch increments the PC modulo 4096, so a fetch from 0xFFF leaves the PC at 0x000.
- R3: When the indirect flag is 1 and the code is 0 to 6, the operand address is replaced by the low 12 bits of the memory word it points to. Only one level is resolved.
- R4: The operation codes and their effects are these. Code 0 sets AC to AC AND M. Code 2 sets AC to M. Code 1 sets AC to the low 16 bits of AC + M and puts the carry-out into E. Codes 0 and 2 leave E unchanged.
- R5: Code 3 writes AC to M[address]. Code 4 sets the PC to the address.
- R6: Code 5 writes the current PC (the address after the call) to M[address] and continues execution at address+1.
- R7: Code 6 writes M[address]+1 back to memory. If the result is 0, it skips the next instruction.
- R8: For code 7, execStrobe is high for exactly one clock during T3, with execIndirect equal to bit 15 and execField equal to bits 11..0. The state that follows is a one-clock wait (timing state 4).
- R9: Clock counts per instruction are as follows. Codes 0, 1, 2 and 5 take 6 clocks. Codes 3 and 4 take 5 clocks. Code 6 takes 7 clocks. Code 7 takes 5 clocks. The indirect flag adds no clocks.
- R10: If haltReq is high at the end of the code-7 wait state, the run flag falls and the timing state returns to 0. The PC, the accumulator and the timing state then hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| haltReq | input | 1 | Halt request from the execute unit, sampled at the end of the code-7 wait state |
| progWe | input | 1 | Loader write enable |
| progAddr | input | 12 | Loader write address |
| progData | input | 16 | Loader write data |
| peekAddr | input | 12 | Memory read-back address |
| peekData | output | 16 | Memory word at peekAddr |
| pcOut | output | 12 | Program counter |
| acOut | output | 16 | Accumulator |
| eOut | output | 1 | Carry latch |
| running | output | 1 | Run flag |
| tState | output | 3 | Current timing state, 0 to 6 |
| execStrobe | output | 1 | Register or I/O operation handed off (T3) |
| execIndirect | output | 1 | Bit 15 of the handed-off instruction |
| execField | output | 12 | Bits 11..0 of the handed-off instruction |

## Verification
The bench sweeps add and AND over a grid of operand pairs that includes 0 and 0xFFFF, so carry-out, no carry and an all-ones AND all appear. A design that drops the carry or clobbers E on a load gives a wrong eOut.

A subroutine program runs a three-pass loop driven by increment-and-skip. It returns through an indirect branch on the word saved by the call. An off-by-one return address, a missed skip or a second level of indirection sends the PC elsewhere and corrupts the stored sum. Further checks cover the following:
- a pointer word with high bits set
- a fetch from the last address, which must wrap the PC
- clock counts per instruction mix
- the fields handed off on the strobe
- that the machine stays frozen after a halt

// File: rtl/seqPkg.sv
`timescale 1ns/1ps
package seqPkg;

  typedef enum logic [2:0] {
    T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
    T4 = 3'd4, T5 = 3'd5, T6 = 3'd6
  } tstate_t;

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_LDA = 3'd2;
  localparam logic [2:0] OP_STA = 3'd3;
  localparam logic [2:0] OP_BUN = 3'd4;
  localparam logic [2:0] OP_BSA = 3'd5;
  localparam logic [2:0] OP_ISZ = 3'd6;
  localparam logic [2:0] OP_EXT = 3'd7;

  // strobes from control to datapath, one per micro-operation
  typedef struct packed {
    logic arFromPc;
    logic arFromIr;
    logic arFromMem;
    logic arInc;
    logic irLoad;
    logic pcInc;
    logic pcFromAr;
    logic skipIfDrZero;
    logic drFromMem;
    logic drInc;
    logic acAnd;
    logic acAdd;
    logic acLoad;
    logic memFromAc;
    logic memFromPc;
    logic memFromDr;
  } seqStrobes_t;

endpackage

// File: rtl/seqMemory.sv
`timescale 1ns/1ps
module seqMemory #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wEn,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wEn) mem[wAddr] <= wData;
  end

  assign rData    = mem[rAddr];
  assign peekData = mem[peekAddr];
endmodule

// File: rtl/seqControl.sv
`timescale 1ns/1ps
module seqControl
  import seqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  opCode,
  input  logic        irIndirect,
  input  logic        haltReq,
  output seqStrobes_t st,
  output logic        execStrobe,
  output logic        running,
  output logic [2:0]  tState
);
  tstate_t sc;
  logic    runQ;
  logic    iFlag;
  logic    clrSc;
  logic    stopNow;

  always_comb begin
    st         = '0;
    clrSc      = 1'b0;
    stopNow    = 1'b0;
    execStrobe = 1'b0;
    if (runQ) begin
      case (sc)
        T0: st.arFromPc = 1'b1;
        T1: begin
          st.irLoad = 1'b1;
          st.pcInc  = 1'b1;
        end
        T2: st.arFromIr = 1'b1;
        T3: begin
          if (opCode == OP_EXT) execStrobe = 1'b1;
          else if (iFlag)       st.arFromMem = 1'b1;
        end
        T4: begin
          case (opCode)
            OP_AND, OP_ADD, OP_LDA, OP_ISZ: st.drFromMem = 1'b1;
            OP_STA: begin st.memFromAc = 1'b1; clrSc = 1'b1; end
            OP_BUN: begin st.pcFromAr  = 1'b1; clrSc = 1'b1; end
            OP_BSA: begin st.memFromPc = 1'b1; st.arInc = 1'b1; end
            default: begin
              if (haltReq) stopNow = 1'b1;
              else         clrSc   = 1'b1;
            end
          endcase
        end
        T5: begin
          case (opCode)
            OP_AND: begin st.acAnd    = 1'b1; clrSc = 1'b1; end
            OP_ADD: begin st.acAdd    = 1'b1; clrSc = 1'b1; end
            OP_LDA: begin st.acLoad   = 1'b1; clrSc = 1'b1; end
            OP_BSA: begin st.pcFromAr = 1'b1; clrSc = 1'b1; end
            OP_ISZ: st.drInc = 1'b1;
            default: clrSc = 1'b1;
          endcase
        end
        T6: begin
          st.memFromDr    = 1'b1;
          st.skipIfDrZero = 1'b1;
          clrSc           = 1'b1;
        end
        default: clrSc = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sc    <= T0;
      runQ  <= 1'b1;
      iFlag <= 1'b0;
    end else if (runQ) begin
      if (stopNow) begin
        runQ <= 1'b0;
        sc   <= T0;
      end else if (clrSc) begin
        sc <= T0;
      end else begin
        sc <= tstate_t'(sc + 3'd1);
      end
      if (sc == T2) iFlag <= irIndirect;
    end
  end

  assign running = runQ;
  assign tState  = sc;

  // R8: after a hand-off strobe the next state is the single wait state
  a_r8_exec_wait: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |=> (sc == T4 && !execStrobe));

  // R9: the timing counter never leaves T0..T6
  a_r9_sc_bound: assert property (@(posedge clk) disable iff (!rstN)
    sc <= T6);

  // R10: once stopped, the machine stays stopped at T0
  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> (!runQ && sc == T0));
endmodule

// File: rtl/seqDatapath.sv
`timescale 1ns/1ps
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       st,
  input  logic [DATA_W-1:0] memRd,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWd,
  output logic [DATA_W-1:0] irQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic [DATA_W-1:0] acQ,
  output logic              eQ
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] arQ;
  logic [DATA_W-1:0] drQ;
  logic [DATA_W:0]   sum;

  assign sum = {1'b0, acQ} + {1'b0, drQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
      arQ <= '0;
      irQ <= '0;
      drQ <= '0;
      acQ <= '0;
      eQ  <= 1'b0;
    end else begin
      if (st.arFromPc)       arQ <= pcQ;
      else if (st.arFromIr)  arQ <= irQ[ADDR_W-1:0];
      else if (st.arFromMem) arQ <= memRd[ADDR_W-1:0];
      else if (st.arInc)     arQ <= arQ + 1'b1;

      if (st.irLoad) irQ <= memRd;

      if (st.pcInc)                              pcQ <= pcQ + 1'b1;
      else if (st.pcFromAr)                      pcQ <= arQ;
      else if (st.skipIfDrZero && drQ == '0)     pcQ <= pcQ + 1'b1;

      if (st.drFromMem)   drQ <= memRd;
      else if (st.drInc)  drQ <= drQ + 1'b1;

      if (st.acAnd)       acQ <= acQ & drQ;
      else if (st.acAdd)  {eQ, acQ} <= sum;
      else if (st.acLoad) acQ <= drQ;
    end
  end

  always_comb begin
    memWd = acQ;
    if (st.memFromPc)      memWd = {{PAD_W{1'b0}}, pcQ};
    else if (st.memFromDr) memWd = drQ;
  end

  assign memWe   = st.memFromAc | st.memFromPc | st.memFromDr;
  assign memAddr = arQ;

  // R2: a fetch advances the PC by one, modulo the address space
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    st.irLoad |=> pcQ == ($past(pcQ) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  // R4: the add leaves the full sum in {E, AC}
  a_r4_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    st.acAdd |=> {eQ, acQ} == ({1'b0, $past(acQ)} + {1'b0, $past(drQ)}));

  // R5: at most one source drives a memory write in any state
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.memFromAc, st.memFromPc, st.memFromDr}));
endmodule

// File: rtl/accSequencer.sv
`timescale 1ns/1ps
module accSequencer #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [ADDR_W+3:0] progData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [ADDR_W+3:0] peekData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W+3:0] acOut,
  output logic              eOut,
  output logic              running,
  output logic [2:0]        tState,
  output logic              execStrobe,
  output logic              execIndirect,
  output logic [ADDR_W-1:0] execField
);
  import seqPkg::*;

  localparam int DATA_W = ADDR_W + 4;

  seqStrobes_t       st;
  logic [DATA_W-1:0] irQ;
  logic [DATA_W-1:0] memRd;
  logic [DATA_W-1:0] memWd;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe;
  logic              wEn;
  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;

  seqControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .opCode     (irQ[DATA_W-2:DATA_W-4]),
    .irIndirect (irQ[DATA_W-1]),
    .haltReq    (haltReq),
    .st         (st),
    .execStrobe (execStrobe),
    .running    (running),
    .tState     (tState)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .memRd   (memRd),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memWd   (memWd),
    .irQ     (irQ),
    .pcQ     (pcOut),
    .acQ     (acOut),
    .eQ      (eOut)
  );

  assign wEn   = progWe | memWe;
  assign wAddr = progWe ? progAddr : memAddr;
  assign wData = progWe ? progData : memWd;

  seqMemory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_memory (
    .clk      (clk),
    .wEn      (wEn),
    .wAddr    (wAddr),
    .wData    (wData),
    .rAddr    (memAddr),
    .rData    (memRd),
    .peekAddr (peekAddr),
    .peekData (peekData)
  );

  assign execIndirect = irQ[DATA_W-1];
  assign execField    = irQ[ADDR_W-1:0];
endmodule

// File: tb/accSequencer_tb.sv
`timescale 1ns/1ps
module accSequencer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        haltReq = 1'b0;
  logic        progWe = 1'b0;
  logic [11:0] progAddr = '0;
  logic [15:0] progData = '0;
  logic [11:0] peekAddr = '0;
  logic [15:0] peekData;
  logic [11:0] pcOut;
  logic [15:0] acOut;
  logic        eOut;
  logic        running;
  logic [2:0]  tState;
  logic        execStrobe;
  logic        execIndirect;
  logic [11:0] execField;

  int checks = 0;
  int errors = 0;
  int strobeCount = 0;
  logic [12:0] strobeLog [8];

  always #10 clk = ~clk;

  accSequencer u_dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .peekAddr(peekAddr), .peekData(peekData),
    .pcOut(pcOut), .acOut(acOut), .eOut(eOut), .running(running),
    .tState(tState), .execStrobe(execStrobe),
    .execIndirect(execIndirect), .execField(execField)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic holdReset();
    rstN = 1'b0;
    haltReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic putWord(input logic [11:0] a, input logic [15:0] d);
    progAddr = a; progData = d; progWe = 1'b1;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [15:0] d);
    peekAddr = a;
    #1;
    d = peekData;
  endtask

  // releases reset and plays the execute unit until the machine stops
  task automatic runProgram(output int cyc);
    cyc = 0;
    strobeCount = 0;
    rstN = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (execStrobe) begin
        if (strobeCount < 8) strobeLog[strobeCount] = {execIndirect, execField};
        strobeCount++;
        haltReq = (execField == 12'h001);
      end else if (tState != 3'd4) begin
        haltReq = 1'b0;
      end
      if (!running) break;
      if (cyc > 3000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=halt", cyc);
        break;
      end
    end
    haltReq = 1'b0;
  endtask

  function automatic logic [15:0] pick(int i);
    if (i == 0) return 16'h0000;
    if (i == 7) return 16'hFFFF;
    return 16'(i * 32'h3A5B + 32'h0F0F);
  endfunction

  initial begin
    int cyc;
    logic [15:0] w;
    logic [16:0] s;

    // R1: reset state
    holdReset();
    check("R1 pc", 32'(pcOut), 32'h0);
    check("R1 ac", 32'(acOut), 32'h0);
    check("R1 e", 32'(eOut), 32'h0);
    check("R1 running", 32'(running), 32'h1);
    check("R1 tState", 32'(tState), 32'h0);

    // R4 R5 R9: add sweep, load/add/store/halt
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        holdReset();
        putWord(12'h000, 16'h2100);
        putWord(12'h001, 16'h1101);
        putWord(12'h002, 16'h3102);
        putWord(12'h003, 16'h7001);
        putWord(12'h100, pick(i));
        putWord(12'h101, pick(j));
        runProgram(cyc);
        s = {1'b0, pick(i)} + {1'b0, pick(j)};
        check("R4 add ac", 32'(acOut), 32'(s[15:0]));
        check("R4 add carry", 32'(eOut), 32'(s[16]));
        peek(12'h102, w);
        check("R5 store", 32'(w), 32'(s[15:0]));
        check("R9 add mix cycles", 32'(cyc), 32'd22);
        check("R2 pc after halt", 32'(pcOut), 32'h004);
      end
    end

    // R4: AND sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        holdReset();
        putWord(12'h000, 16'h2100);
        putWord(12'h001, 16'h0101);
        putWord(12'h002, 16'h3102);
        putWord(12'h003, 16'h7001);
        putWord(12'h100, pick(i));
        putWord(12'h101, pick(j));
        runProgram(cyc);
        check("R4 and ac", 32'(acOut), 32'(pick(i) & pick(j)));
        check("R4 and keeps e", 32'(eOut), 32'h0);
        peek(12'h102, w);
        check("R5 store and", 32'(w), 32'(pick(i) & pick(j)));
      end
    end

    // R4: a load after a carrying add leaves E set
    holdReset();
    putWord(12'h000, 16'h2100);
    putWord(12'h001, 16'h1101);
    putWord(12'h002, 16'h2102);
    putWord(12'h003, 16'h7001);
    putWord(12'h100, 16'hFFFF);
    putWord(12'h101, 16'h0002);
    putWord(12'h102, 16'h1234);
    runProgram(cyc);
    check("R4 load ac", 32'(acOut), 32'h1234);
    check("R4 load keeps e", 32'(eOut), 32'h1);

    // R3: indirect load and store, pointer with high bits set
    holdReset();
    putWord(12'h000, 16'hA070);
    putWord(12'h001, 16'hB071);
    putWord(12'h002, 16'h7001);
    putWord(12'h070, 16'hF075);
    putWord(12'h071, 16'h0080);
    putWord(12'h075, 16'hBEEF);
    putWord(12'h080, 16'h0000);
    runProgram(cyc);
    check("R3 indirect load", 32'(acOut), 32'hBEEF);
    peek(12'h080, w);
    check("R3 indirect store target", 32'(w), 32'hBEEF);
    peek(12'h071, w);
    check("R3 pointer untouched", 32'(w), 32'h0080);
    check("R9 indirect adds no cycles", 32'(cyc), 32'd16);

    // R6 R7 R3 R5: call, increment-and-skip loop, indirect return
    holdReset();
    putWord(12'h000, 16'h2050);
    putWord(12'h001, 16'h5060);
    putWord(12'h002, 16'h3052);
    putWord(12'h003, 16'h7001);
    putWord(12'h061, 16'h1051);
    putWord(12'h062, 16'h6053);
    putWord(12'h063, 16'h4061);
    putWord(12'h064, 16'hC060);
    putWord(12'h050, 16'h0005);
    putWord(12'h051, 16'h0003);
    putWord(12'h053, 16'hFFFD);
    runProgram(cyc);
    check("R7 loop sum ac", 32'(acOut), 32'd14);
    peek(12'h052, w);
    check("R6 return stored sum", 32'(w), 32'd14);
    peek(12'h060, w);
    check("R6 saved return address", 32'(w), 32'h0002);
    peek(12'h053, w);
    check("R7 counter reaches zero", 32'(w), 32'h0000);
    check("R6 pc after halt", 32'(pcOut), 32'h004);
    check("R9 program cycles", 32'(cyc), 32'd76);

    // R8 R9: hand-off fields and wait
    holdReset();
    putWord(12'h000, 16'h7800);
    putWord(12'h001, 16'hF123);
    putWord(12'h002, 16'h7001);
    runProgram(cyc);
    check("R8 strobe count", 32'(strobeCount), 32'd3);
    check("R8 first field", 32'(strobeLog[0]), 32'h0800);
    check("R8 indirect field", 32'(strobeLog[1]), 32'h1123);
    check("R8 halt field", 32'(strobeLog[2]), 32'h0001);
    check("R9 hand-off cycles", 32'(cyc), 32'd15);
    check("R8 ac untouched", 32'(acOut), 32'h0);

    // R2: PC wraps from the last address; R10: freeze after halt
    holdReset();
    putWord(12'h000, 16'h4FFF);
    putWord(12'hFFF, 16'h7001);
    runProgram(cyc);
    check("R2 pc wrap", 32'(pcOut), 32'h000);
    check("R5 branch cycles", 32'(cyc), 32'd10);
    for (int k = 0; k < 8; k++) @(negedge clk);
    check("R10 running low", 32'(running), 32'h0);
    check("R10 pc held", 32'(pcOut), 32'h000);
    check("R10 tState held", 32'(tState), 32'h0);
    check("R10 ac held", 32'(acOut), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule